// File: doc/BRIEF.md
# Grouped Weight-Priority Spike Scheduler

This block decides which of many buffered input ports of a spike-routing node may send its packet to the single shared output channel in a given cycle. The ports are arranged as `NUM_GROUPS` groups of `GROUP_PORTS` ports. Each port supplies a data-present flag from its input FIFO and a small traffic weight, which is computed outside this block. Inside every group, a comparator selects the eligible port with the heaviest weight. A round-robin pointer then picks one of the group winners.

The granted port receives a read enable for one cycle in the same cycle that its present flag is seen. The input FIFO must run in first-word-fall-through mode, so the packet is already at its output while the read enable is high. The scheduler registers that packet and presents it on the output bus, together with a write enable, on the following cycle. No grant is issued while the downstream full flag is high.

The asynchronous active-low reset is released through a two-stage synchroniser. Grants start on the second rising edge after `rst_n` goes high.

Top module: `spike_sched_top`

## Requirements
- R1: While reset is active, all read enables and `out_wr_en` are 0 and `out_data` is 0, whatever the inputs. After reset the round-robin pointer starts at group 0.
- R2: Within a group, the eligible port with the largest weight is the group winner. Port p of group g is flat index g*GROUP_PORTS+p. Its weight is bits [i*WEIGHT_W +: WEIGHT_W] of `port_weight`, and its packet is bits [i*PKT_W +: PKT_W] of `port_data`, where i is the flat index.
- R3: When eligible ports of a group have equal weights, the lowest-indexed of them wins.
- R4: A port whose present flag is 0 is never granted, whatever its weight.
- R5: Among the groups that have a winner, the first one found searching upward from the pointer (wrapping) is granted. Groups with no eligible port are skipped. After a grant, the pointer moves to the group after the granted one.
- R6: While `out_full` is 1, no read enable is asserted and the pointer does not move.
- R7: At most one bit of `port_rd_en` is 1 in any cycle.
- R8: The read enable appears in the same cycle that the present flag is seen. The granted packet appears on `out_data` with `out_wr_en`=1 exactly one cycle later, well inside 3 cycles of arrival.
- R9: In a cycle after one with no grant, `out_wr_en` is 0 and `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_present | input | NUM_GROUPS*GROUP_PORTS | Per-port FIFO not-empty flag |
| port_weight | input | NUM_GROUPS*GROUP_PORTS*WEIGHT_W | Per-port traffic weight, unsigned |
| port_data | input | NUM_GROUPS*GROUP_PORTS*PKT_W | Per-port FIFO head packet (first-word-fall-through) |
| out_full | input | 1 | Downstream cannot take a new grant |
| port_rd_en | output | NUM_GROUPS*GROUP_PORTS | One-cycle FIFO read enable of the granted port |
| out_data | output | PKT_W | Forwarded packet |
| out_wr_en | output | 1 | Write enable for `out_data` |

## Verification
The bench targets these corner cases:
- A heavy port with its present flag low. A design that ignores the flag would grant an empty FIFO.
- Equal weights inside a group. A wrong tie rule would pick a higher-indexed port.
- A group with no eligible port placed between busy groups. A pointer that does not skip it would stall for a cycle, and one that advances wrongly would starve a group.
- Grants offered while `out_full` is high, which must neither pop a FIFO nor move the pointer.
- Idle cycles after a grant, where a stuck write enable would duplicate a packet.

A behavioural model compares every read enable, write enable and output word on every cycle, under both directed and random traffic.

// File: rtl/spike_sched_pkg.sv
package spike_sched_pkg;
  // Index width that stays at least one bit wide for a count of one.
  function automatic int idx_width(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/group_max_sel.sv
module group_max_sel
  import spike_sched_pkg::*;
#(
  parameter int GROUP_PORTS = 8,
  parameter int WEIGHT_W    = 3,
  localparam int IDX_W      = idx_width(GROUP_PORTS)
) (
  input  logic [GROUP_PORTS-1:0]          present,
  input  logic [GROUP_PORTS*WEIGHT_W-1:0] weight,
  output logic                            win_valid,
  output logic [IDX_W-1:0]                win_idx
);

  logic [WEIGHT_W-1:0] best_w;

  // Strict greater-than keeps the lowest index on ties (R3); absent ports skipped (R4).
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    best_w    = '0;
    for (int p = 0; p < GROUP_PORTS; p++) begin
      if (present[p] && (!win_valid || weight[p*WEIGHT_W +: WEIGHT_W] > best_w)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(p);
        best_w    = weight[p*WEIGHT_W +: WEIGHT_W];
      end
    end
  end

endmodule

// File: rtl/group_rr_pick.sv
module group_rr_pick
  import spike_sched_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  localparam int GRP_W     = idx_width(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GROUPS-1:0] req,
  input  logic                  take,
  output logic                  pick_valid,
  output logic [GRP_W-1:0]      pick_grp
);

  logic [GRP_W-1:0] ptr_q, ptr_d;

  always_comb begin
    pick_valid = 1'b0;
    pick_grp   = '0;
    for (int k = 0; k < NUM_GROUPS; k++) begin
      int g;
      g = int'(ptr_q) + k;
      if (g >= NUM_GROUPS) g = g - NUM_GROUPS;
      if (!pick_valid && req[g]) begin
        pick_valid = 1'b1;
        pick_grp   = GRP_W'(g);
      end
    end
  end

  always_comb begin
    ptr_d = ptr_q;
    if (take && pick_valid) begin
      if (int'(pick_grp) == NUM_GROUPS - 1) ptr_d = '0;
      else                                  ptr_d = pick_grp + GRP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R5: only a requesting group can be picked.
  assert_pick_requests_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> req[pick_grp]);

  // R6: pointer holds when nothing is taken.
  assert_ptr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(ptr_q));

endmodule

// File: rtl/spike_sched_top.sv
module spike_sched_top
  import spike_sched_pkg::*;
#(
  parameter int NUM_GROUPS  = 3,
  parameter int GROUP_PORTS = 8,
  parameter int WEIGHT_W    = 3,
  parameter int PKT_W       = 62,
  localparam int NPORTS     = NUM_GROUPS * GROUP_PORTS,
  localparam int IDX_W      = idx_width(GROUP_PORTS),
  localparam int GRP_W      = idx_width(NUM_GROUPS),
  localparam int PORT_W     = idx_width(NPORTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORTS-1:0]          port_present,
  input  logic [NPORTS*WEIGHT_W-1:0] port_weight,
  input  logic [NPORTS*PKT_W-1:0]    port_data,
  input  logic                       out_full,
  output logic [NPORTS-1:0]          port_rd_en,
  output logic [PKT_W-1:0]           out_data,
  output logic                       out_wr_en
);

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_i = rst_pipe[1];

  // Per-group weight comparators.
  logic [NUM_GROUPS-1:0] grp_valid;
  logic [IDX_W-1:0]      grp_idx [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    group_max_sel #(
      .GROUP_PORTS(GROUP_PORTS),
      .WEIGHT_W   (WEIGHT_W)
    ) u_sel (
      .present  (port_present[g*GROUP_PORTS +: GROUP_PORTS]),
      .weight   (port_weight[g*GROUP_PORTS*WEIGHT_W +: GROUP_PORTS*WEIGHT_W]),
      .win_valid(grp_valid[g]),
      .win_idx  (grp_idx[g])
    );
  end

  // Round-robin across group winners.
  logic             pick_valid;
  logic [GRP_W-1:0] pick_grp;
  logic             grant;

  assign grant = pick_valid & ~out_full & rst_n_i;

  group_rr_pick #(.NUM_GROUPS(NUM_GROUPS)) u_rr (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .req       (grp_valid),
    .take      (grant),
    .pick_valid(pick_valid),
    .pick_grp  (pick_grp)
  );

  // Selected flat port and read enable.
  logic [PORT_W-1:0] sel_port;
  logic [PKT_W-1:0]  sel_data;

  always_comb begin
    sel_port   = PORT_W'(pick_grp) * PORT_W'(GROUP_PORTS) + PORT_W'(grp_idx[pick_grp]);
    sel_data   = port_data[sel_port*PKT_W +: PKT_W];
    port_rd_en = grant ? (NPORTS'(1) << sel_port) : '0;
  end

  // Output register with explicit load enable.
  logic [PKT_W-1:0] out_data_d;
  logic             out_wr_en_d;

  always_comb begin
    out_wr_en_d = grant;
    out_data_d  = grant ? sel_data : out_data;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      out_data  <= '0;
      out_wr_en <= 1'b0;
    end else begin
      out_data  <= out_data_d;
      out_wr_en <= out_wr_en_d;
    end
  end

  // R7: one read enable at most.
  assert_single_rd_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    $onehot0(port_rd_en));

  // R4: never read an empty FIFO.
  assert_rd_present_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (port_rd_en & ~port_present) == '0);

  // R6: nothing granted while full.
  assert_full_block_R6: assert property (@(posedge clk) disable iff (!rst_n_i)
    out_full |-> (port_rd_en == '0));

  // R8: a read enable is followed by a write.
  assert_forward_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (|port_rd_en) |=> out_wr_en);

  // R9: no grant, no write, data held.
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    (port_rd_en == '0) |=> (!out_wr_en && $stable(out_data)));

endmodule

// File: tb/spike_sched_top_test.sv
module spike_sched_top_test;
  localparam int NG = 3;
  localparam int GP = 8;
  localparam int WW = 3;
  localparam int PW = 62;
  localparam int NP = NG * GP;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [NP-1:0]     port_present;
  logic [NP*WW-1:0]  port_weight;
  logic [NP*PW-1:0]  port_data;
  logic              out_full;
  logic [NP-1:0]     port_rd_en;
  logic [PW-1:0]     out_data;
  logic              out_wr_en;

  always #2 clk = ~clk;  // 250 MHz

  spike_sched_top #(.NUM_GROUPS(NG), .GROUP_PORTS(GP), .WEIGHT_W(WW), .PKT_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .port_present(port_present), .port_weight(port_weight),
    .port_data(port_data), .out_full(out_full), .port_rd_en(port_rd_en),
    .out_data(out_data), .out_wr_en(out_wr_en)
  );

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  // Reference model state
  int          m_ptr = 0;
  logic        m_wr = 1'b0;
  logic [PW-1:0] m_data = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_ports();
    port_present = '0;
    port_weight  = '0;
    out_full     = 1'b0;
  endtask

  task automatic set_port(input int p, input bit pres, input int w);
    port_present[p] = pres;
    port_weight[p*WW +: WW] = WW'(w);
    port_data[p*PW +: PW] = {$urandom(), $urandom()};
  endtask

  // Compare one cycle against the model and advance the model.
  task automatic step();
    logic [NP-1:0] exp_rd;
    int gsel;
    int psel;
    #1;
    exp_rd = '0;
    gsel = -1;
    psel = -1;
    if (!out_full) begin
      for (int k = 0; k < NG && gsel < 0; k++) begin
        int g;
        int bw;
        g = (m_ptr + k) % NG;
        bw = -1;
        for (int p = 0; p < GP; p++) begin
          int i;
          i = g * GP + p;
          if (port_present[i] && int'(port_weight[i*WW +: WW]) > bw) begin
            bw = int'(port_weight[i*WW +: WW]);
            psel = i;
          end
        end
        if (bw >= 0) gsel = g;
      end
    end
    if (gsel >= 0) exp_rd[psel] = 1'b1;
    chk(port_rd_en == exp_rd, tag, "rd_en", 128'(port_rd_en), 128'(exp_rd));
    chk($countones(port_rd_en) <= 1, "R7", "rd_en count", 128'($countones(port_rd_en)), 128'(1));
    chk(out_wr_en == m_wr, m_wr ? "R8" : "R9", "out_wr_en", 128'(out_wr_en), 128'(m_wr));
    chk(out_data == m_data, m_wr ? "R8" : "R9", "out_data", 128'(out_data), 128'(m_data));
    if (gsel >= 0) begin
      m_ptr  = (gsel + 1) % NG;
      m_wr   = 1'b1;
      m_data = port_data[psel*PW +: PW];
    end else begin
      m_wr = 1'b0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    clear_ports();
    port_data = '0;
    for (int p = 0; p < NP; p++) set_port(p, 1'b1, 7);
    repeat (3) @(negedge clk);
    #1;
    // R1: outputs quiet under reset even with every port present
    chk(port_rd_en == '0, "R1", "rd_en in reset", 128'(port_rd_en), 128'(0));
    chk(out_wr_en == 1'b0, "R1", "wr_en in reset", 128'(out_wr_en), 128'(0));
    chk(out_data == '0, "R1", "data in reset", 128'(out_data), 128'(0));
    @(negedge clk);
    clear_ports();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: pointer starts at group 0: all groups equal, port 0 wins
    tag = "R1";
    for (int p = 0; p < NP; p++) set_port(p, 1'b1, 2);
    step();
    clear_ports(); step(); step();

    // R2: heaviest port in a group wins
    tag = "R2";
    set_port(2, 1, 3); set_port(5, 1, 6); set_port(7, 1, 1);
    set_port(8, 1, 1); set_port(13, 1, 5); set_port(20, 1, 4);
    step(); step();
    clear_ports(); step();

    // R3: ties go to the lowest index
    tag = "R3";
    set_port(3, 1, 4); set_port(6, 1, 4); set_port(1, 1, 2);
    set_port(12, 1, 4); set_port(9, 1, 4);
    set_port(22, 1, 7); set_port(17, 1, 7);
    step(); step(); step();
    clear_ports(); step();

    // R4: absent heavy port is ignored
    tag = "R4";
    set_port(4, 0, 7); set_port(0, 1, 1); set_port(14, 0, 7); set_port(23, 0, 7);
    step();
    set_port(0, 0, 1);
    step();
    clear_ports(); step();

    // R5: group 1 empty, groups 0 and 2 alternate
    tag = "R5";
    set_port(1, 1, 3); set_port(18, 1, 2);
    for (int n = 0; n < 6; n++) step();
    clear_ports(); step();

    // R6: full blocks grants and freezes the pointer
    tag = "R6";
    set_port(9, 1, 5); set_port(2, 1, 5);
    out_full = 1'b1;
    step(); step(); step();
    out_full = 1'b0;
    step(); step();
    clear_ports(); step(); step();

    // Random traffic, full toggling
    tag = "R2";
    for (int n = 0; n < 400; n++) begin
      for (int p = 0; p < NP; p++) set_port(p, ($urandom() % 3) == 0, $urandom() % 8);
      out_full = ($urandom() % 5) == 0;
      step();
      if ((n % 7) == 0) begin clear_ports(); step(); end
    end
    clear_ports(); step(); step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule